// File: doc/BRIEF.md
# Multi-lane video pixel serializer

This block turns one parallel video pixel per pixel period into a serial stream on one, two or three data lanes. It also forwards a bit clock in which every serial bit has its own edge. Each pixel becomes a 30-bit word. The word holds 24 colour bits, the three timing flags (horizontal sync, vertical sync, data enable), two general-purpose bits and an even-parity bit.

While data enable is low, no visible pixels are being sent, so the colour field carries a fixed synchronization pattern in place of the colour bits. A receiver that is clocked by the forwarded bit clock can use this pattern to find the first bit of a pixel without a local PLL.

The block runs entirely on the bit-rate clock, which comes from an external multiplier. It pulses `pix_load_o` in the cycle whose closing edge captures the pixel inputs, so the pixel source can present one pixel per pulse. The lane count is taken from `lane_sel_i` while reset is held.

Top module: `vid_lane_serializer`

## Requirements
- R1: The 30-bit word is, from bit 29 down to bit 0: red[7:0], green[7:0], blue[7:0], hsync, vsync, data enable, gp[1:0], parity.
- R2: Bit 0 of the word is chosen so that the whole 30-bit word has an even number of ones.
- R3: When data enable is low, word bits 29..6 carry the constant 24'hA53C0F in place of the colour inputs. When data enable is high, the colour inputs pass unchanged, even if they equal that constant.
- R4: Word bit 29 is sent first. With N lanes, the bit at send position i (0 = bit 29) goes to lane i mod N in slot floor(i/N) after the load edge. Slot 0 is visible in the cycle after that edge.
- R5: `lane_sel_i` sampled during reset selects the lane count N: values 0 and 1 give 1 lane, 2 gives 2 lanes, 3 gives 3 lanes. `pix_load_o` is high in the first cycle after reset and then once every 30/N cycles (30, 15 or 10).
- R6: Lanes with an index of N or higher drive 0 at all times.
- R7: `bclk_o` is 0 in reset and toggles on every clock edge, so each serial bit period contains exactly one forwarded clock transition.
- R8: Changes on `lane_sel_i` after reset is released have no effect on the lane count or on the lane mapping.
- R9: In reset, all lanes drive 0 and `pix_load_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_sel_i | input | 2 | Lane count setting, sampled in reset |
| red_i | input | 8 | Red component |
| grn_i | input | 8 | Green component |
| blu_i | input | 8 | Blue component |
| hsync_i | input | 1 | Horizontal sync flag |
| vsync_i | input | 1 | Vertical sync flag |
| de_i | input | 1 | Data enable (visible pixel) |
| gp_i | input | 2 | General-purpose bits |
| pix_load_o | output | 1 | High in the cycle whose closing edge captures the pixel inputs |
| lane_o | output | 3 | Serial data, one bit per lane |
| bclk_o | output | 1 | Forwarded double-data-rate bit clock |

## Verification
The embedded properties watch, on every cycle, the following behaviours:
- pixel loads never come back to back;
- the forwarded clock always toggles;
- lanes at or above the configured count stay silent;
- the lane count is frozen after reset;
- each freshly loaded word has even parity;
- the first serial bit after a load is either the head of the sync pattern or the captured red MSB, depending on data enable.

The exact slot-by-slot lane mapping, the load period for each lane count, and the insensitivity to later changes of the setting are shown only by the bench. The bench sweeps every setting value through fixed, walking-one and pseudo-random pixels, including colour data that matches the sync constant.

// File: rtl/vls_pkg.sv
package vls_pkg;
    localparam int COLOR_W   = 8;
    localparam int GP_W      = 2;
    localparam int RGB_W     = 3 * COLOR_W;
    localparam int CTRL_W    = 3;
    localparam int WORD_W    = RGB_W + CTRL_W + GP_W + 1;
    localparam int LANES_MAX = 3;
    localparam int LCNT_W    = $clog2(LANES_MAX + 1);
    localparam int CNT_W     = $clog2(WORD_W);

    localparam logic [RGB_W-1:0] SYNC_PAT = RGB_W'(24'hA53C0F);

    typedef struct packed {
        logic [COLOR_W-1:0] red;
        logic [COLOR_W-1:0] grn;
        logic [COLOR_W-1:0] blu;
        logic               hs;
        logic               vs;
        logic               de;
        logic [GP_W-1:0]    gp;
    } pix_t;

    // Setting value to active lane count (0 and 1 both mean one lane).
    function automatic logic [LCNT_W-1:0] lane_count(input logic [LCNT_W-1:0] sel);
        if (sel == '0)
            return LCNT_W'(1);
        else if (int'(sel) > LANES_MAX)
            return LCNT_W'(LANES_MAX);
        else
            return sel;
    endfunction

    // Serial slots per pixel on each lane for a given lane count.
    function automatic logic [CNT_W-1:0] slots_for(input logic [LCNT_W-1:0] n);
        int nn;
        nn = (n == '0) ? 1 : int'(n);
        return CNT_W'((WORD_W + nn - 1) / nn);
    endfunction
endpackage

// File: rtl/vls_word_pack.sv
module vls_word_pack
    import vls_pkg::*;
(
    input  pix_t              pix,
    output logic [WORD_W-1:0] word
);
    pix_t body;

    always_comb begin
        body = pix;
        if (!pix.de) begin
            body.red = SYNC_PAT[RGB_W-1 -: COLOR_W];
            body.grn = SYNC_PAT[RGB_W-COLOR_W-1 -: COLOR_W];
            body.blu = SYNC_PAT[COLOR_W-1:0];
        end
        word = {body, ^body};
    end
endmodule

// File: rtl/vls_lane_cfg.sv
module vls_lane_cfg
    import vls_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LCNT_W-1:0] sel,
    output logic [LCNT_W-1:0] nlanes,
    output logic [CNT_W-1:0]  last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            nlanes <= lane_count(sel);
            last   <= slots_for(lane_count(sel)) - CNT_W'(1);
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($stable(nlanes) && $stable(last)));  // R8
endmodule

// File: rtl/vls_lane_shift.sv
module vls_lane_shift
    import vls_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LCNT_W-1:0]    nlanes,
    input  logic [CNT_W-1:0]     last,
    input  logic [WORD_W-1:0]    load_word,
    output logic                 pix_load,
    output logic [LANES_MAX-1:0] lane_o
);
    logic [WORD_W-1:0] sreg;
    logic [CNT_W-1:0]  cnt;

    assign pix_load = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (pix_load) begin
            sreg <= load_word;
            cnt  <= last;
        end else begin
            sreg <= sreg << nlanes;
            cnt  <= cnt - CNT_W'(1);
        end
    end

    for (genvar l = 0; l < LANES_MAX; l++) begin : g_lane
        localparam logic [LCNT_W-1:0] LIDX = LCNT_W'(l);
        assign lane_o[l] = (LIDX < nlanes) ? sreg[WORD_W-1-l] : 1'b0;
    end

    AST_WORD_EVEN: assert property (@(posedge clk) disable iff (rst)
        pix_load |=> (^sreg == 1'b0));  // R2
endmodule

// File: rtl/vls_bclk_fwd.sv
module vls_bclk_fwd (
    input  logic clk,
    input  logic rst,
    output logic bclk
);
    always_ff @(posedge clk) begin
        if (rst) bclk <= 1'b0;
        else     bclk <= ~bclk;
    end
endmodule

// File: rtl/vid_lane_serializer.sv
module vid_lane_serializer
    import vls_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LCNT_W-1:0]    lane_sel_i,
    input  logic [COLOR_W-1:0]   red_i,
    input  logic [COLOR_W-1:0]   grn_i,
    input  logic [COLOR_W-1:0]   blu_i,
    input  logic                 hsync_i,
    input  logic                 vsync_i,
    input  logic                 de_i,
    input  logic [GP_W-1:0]      gp_i,
    output logic                 pix_load_o,
    output logic [LANES_MAX-1:0] lane_o,
    output logic                 bclk_o
);
    pix_t              pix;
    logic [WORD_W-1:0] word;
    logic [LCNT_W-1:0] nlanes;
    logic [CNT_W-1:0]  last;

    assign pix = '{red: red_i, grn: grn_i, blu: blu_i,
                   hs: hsync_i, vs: vsync_i, de: de_i, gp: gp_i};

    vls_word_pack u_pack (.pix(pix), .word(word));

    vls_lane_cfg u_cfg (
        .clk(clk), .rst(rst), .sel(lane_sel_i),
        .nlanes(nlanes), .last(last)
    );

    vls_lane_shift u_shift (
        .clk(clk), .rst(rst), .nlanes(nlanes), .last(last),
        .load_word(word), .pix_load(pix_load_o), .lane_o(lane_o)
    );

    vls_bclk_fwd u_bclk (.clk(clk), .rst(rst), .bclk(bclk_o));

    AST_LOAD_SPACED: assert property (@(posedge clk) disable iff (rst)
        pix_load_o |=> !pix_load_o);  // R5
    AST_SYNC_HEAD: assert property (@(posedge clk) disable iff (rst)
        (pix_load_o && !de_i) |=> (lane_o[0] == SYNC_PAT[RGB_W-1]));  // R3
    AST_PIXEL_HEAD: assert property (@(posedge clk) disable iff (rst)
        (pix_load_o && de_i) |=> (lane_o[0] == $past(red_i[COLOR_W-1])));  // R4
    AST_BCLK_EDGE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (bclk_o != $past(bclk_o)));  // R7

    for (genvar l = 1; l < LANES_MAX; l++) begin : g_idle_chk
        AST_IDLE_LANE: assert property (@(posedge clk) disable iff (rst)
            (int'(nlanes) <= l) |-> !lane_o[l]);  // R6
    end
endmodule

// File: tb/vid_lane_serializer_bench.sv
module vid_lane_serializer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] lane_sel_i = 2'd0;
    logic [7:0] red_i = '0, grn_i = '0, blu_i = '0;
    logic       hsync_i = 1'b0, vsync_i = 1'b0, de_i = 1'b0;
    logic [1:0] gp_i = '0;
    logic       pix_load_o;
    logic [2:0] lane_o;
    logic       bclk_o;

    int total = 0;
    int bad = 0;
    int bcnt = 0;
    bit done = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #10 clk = ~clk;  // 50 MHz

    vid_lane_serializer u_vid_lane_serializer (
        .clk(clk), .rst(rst), .lane_sel_i(lane_sel_i),
        .red_i(red_i), .grn_i(grn_i), .blu_i(blu_i),
        .hsync_i(hsync_i), .vsync_i(vsync_i), .de_i(de_i), .gp_i(gp_i),
        .pix_load_o(pix_load_o), .lane_o(lane_o), .bclk_o(bclk_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [29:0] exp_word(input logic [7:0] r, g, b,
                                             input logic hs, vs, de, input logic [1:0] gp);
        logic [28:0] body;
        body = {r, g, b, hs, vs, de, gp};
        if (!de) body[28:5] = 24'hA53C0F;
        return {body, ^body};
    endfunction

    function automatic logic exp_bit(input logic [29:0] w, input int n, input int l, input int s);
        int idx;
        if (l >= n) return 1'b0;
        idx = s * n + l;
        if (idx >= 30) return 1'b0;
        return w[29 - idx];
    endfunction

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic do_reset(input logic [1:0] sel);
        rst = 1'b1;
        lane_sel_i = sel;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        bcnt = 0;
        // R9: reset state visible before the first post-reset edge
        chk(lane_o == 3'b000, "R9 lanes idle", int'(lane_o), 0);
        chk(bclk_o == 1'b0, "R7 bclk reset", int'(bclk_o), 0);
        chk(pix_load_o == 1'b1, "R9 load pending", int'(pix_load_o), 1);
    endtask

    // Called at a negedge where pix_load_o is expected high.
    task automatic run_pixel(input int n, input logic [7:0] r, g, b,
                             input logic hs, vs, de, input logic [1:0] gp);
        logic [29:0] w;
        int per;
        per = 30 / n;
        chk(pix_load_o == 1'b1, "R5 load strobe", int'(pix_load_o), 1);
        red_i = r; grn_i = g; blu_i = b;
        hsync_i = hs; vsync_i = vs; de_i = de; gp_i = gp;
        w = exp_word(r, g, b, hs, vs, de, gp);
        chk((^w) == 1'b0, "R2 parity model", int'(^w), 0);
        for (int s = 0; s < per; s++) begin
            @(posedge clk);
            @(negedge clk);
            bcnt++;
            chk(bclk_o == bcnt[0], "R7 bclk toggle", int'(bclk_o), bcnt[0]);
            for (int l = 0; l < 3; l++) begin
                logic e;
                e = exp_bit(w, n, l, s);
                if (l >= n)
                    chk(lane_o[l] == 1'b0, "R6 unused lane", int'(lane_o[l]), 0);
                else if (s == 0 && l == 0)
                    chk(lane_o[l] == e, "R1 R3 first bit", int'(lane_o[l]), int'(e));
                else
                    chk(lane_o[l] == e, "R4 lane mapping", int'(lane_o[l]), int'(e));
            end
            if (s != per - 1)
                chk(pix_load_o == 1'b0, "R5 no early load", int'(pix_load_o), 0);
        end
    endtask

    initial begin
        for (int sel = 0; sel < 4; sel++) begin
            int n;
            n = (sel == 0) ? 1 : sel;
            do_reset(2'(sel));
            // R8: setting moved after reset must not matter
            lane_sel_i = 2'((sel + 1) % 4);
            run_pixel(n, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 2'b00);
            run_pixel(n, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 2'b11);
            // R3: blanking replaces colour with sync constant
            run_pixel(n, 8'h12, 8'h34, 8'h56, 1'b1, 1'b0, 1'b0, 2'b01);
            run_pixel(n, 8'hFF, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b0, 2'b10);
            // R3: colour equal to the constant passes through with DE high
            run_pixel(n, 8'hA5, 8'h3C, 8'h0F, 1'b0, 1'b0, 1'b1, 2'b00);
            lane_sel_i = 2'((sel + 2) % 4);  // R8
            for (int k = 0; k < 24; k++) begin
                logic [23:0] c;
                c = 24'h1 << k;
                run_pixel(n, c[23:16], c[15:8], c[7:0], k[0], k[1], 1'b1, k[3:2]);
            end
            for (int k = 0; k < 16; k++) begin
                rng = next_rng(rng);
                run_pixel(n, rng[31:24], rng[23:16], rng[15:8],
                          rng[7], rng[6], rng[5] | rng[4], rng[1:0]);
            end
        end
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule